// File: doc/BRIEF.md
# DDR3 Post-Write Command Timing Checker

This block watches the command stream a DDR3 memory controller sends and tells it, cycle by cycle, whether the next READ, WRITE or PRECHARGE may go out without breaking the timing rules that follow a WRITE. A WRITE's data burst ends a fixed number of clocks after the command. That span is the write latency plus the burst duration: four clocks for a full eight-beat burst and two clocks for a chopped four-beat burst. The write-to-read and write-to-precharge delays are counted from that end point, not from the command itself.

Each WRITE starts a global write-to-write timer and a global write-to-read timer. It also starts a write-recovery timer for the bank it targets. A WRITE with auto precharge also marks its bank busy, because the device closes the row on its own. The bank stays busy until the write recovery and the row precharge time have both elapsed after the burst. A parameter sets the burst length handling: fixed full bursts, fixed chopped bursts, or a choice made by each command's chop flag.

If a command arrives while its allowed flag is low, the block raises a one-cycle violation pulse and records the offending opcode.

Top module: `wr_turnaround_guard`

## Requirements
- R1: After reset, `wr_ok` and `rd_ok` are high, every `pre_ok` bit is high, every `bank_busy` bit is low and `viol` is low.
- R2: A valid WRITE (opcode 2) issued in cycle t drives `wr_ok` low from cycle t+1 up to cycle t+T_CCD-1. `wr_ok` is high again in cycle t+T_CCD.
- R3: The write burst of a command in cycle t ends at t+WL+4 for a full burst and at t+WL+2 for a chopped burst. With BL_MODE=0 every burst is full. With BL_MODE=1 every burst is chopped. With BL_MODE=2, `cmd_bc`=1 selects a chopped burst and 0 selects a full burst.
- R4: After a WRITE, `rd_ok` stays low until the burst end plus T_WTR clocks.
- R5: After a WRITE to bank b, `pre_ok[b]` stays low until the burst end plus T_WR clocks. The `pre_ok` bits of the other banks are not affected.
- R6: A WRITE to bank b with `cmd_ap`=1 holds `bank_busy[b]` high until the burst end plus T_WR plus T_RP clocks. `pre_ok[b]` is low while the bank is busy.
- R7: `viol` pulses high in cycle t+1, for one cycle, if the command valid in cycle t breaks a rule. A READ (opcode 1) breaks a rule when `rd_ok` is low or its bank is busy. A WRITE breaks a rule when `wr_ok` is low or its bank is busy. A PRECHARGE (opcode 3) breaks a rule when `pre_ok` of its bank is low. Opcode 0 is a no-op.
- R8: `viol_op` takes the opcode of each offending command and holds it until the next violation.
- R9: A WRITE that breaks a rule still starts its timers, as if it had been issued normally.
- R10: Input cycles with `cmd_vld`=0 have no effect on any flag or timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Opcode: 0 no-op, 1 READ, 2 WRITE, 3 PRECHARGE |
| cmd_bank | input | BANK_W | Target bank |
| cmd_ap | input | 1 | Auto precharge requested with a WRITE |
| cmd_bc | input | 1 | Chopped burst requested (used when BL_MODE=2) |
| wr_ok | output | 1 | A WRITE may be issued this cycle |
| rd_ok | output | 1 | A READ may be issued this cycle |
| pre_ok | output | NUM_BANKS | Per bank: a PRECHARGE may be issued this cycle |
| bank_busy | output | NUM_BANKS | Per bank: an auto precharge is still in progress |
| viol | output | 1 | One-cycle pulse for a rule-breaking command |
| viol_op | output | 2 | Opcode of the last rule-breaking command |

## Verification
The bench builds the block with four banks, BL_MODE=2 and the default timings (WL=5, T_CCD=4, T_WTR=4, T_WR=8, T_RP=5). Selecting the burst per command lets one run reach both burst end points: full bursts and chopped bursts back to back, and a PRECHARGE placed exactly on a chopped burst's recovery edge. The short T_CCD lets a WRITE land exactly on the allowed edge and one cycle before it. The auto-precharge window is long enough to place a READ after `rd_ok` has returned while the bank is still busy.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2,
      OP_PRE = 2'd3
   } wrg_op_e;
endpackage

// File: rtl/wrg_timer.sv
// Down counter: a load keeps the larger of the new value and the running one.
module wrg_timer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);
   logic [W-1:0] cnt, nxt;

   always_comb nxt = (cnt == '0) ? '0 : cnt - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (load && val > nxt) cnt <= val;
      else                        cnt <= nxt;
   end

   assign expired = (cnt == '0);

   a_r9_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (load && val != '0) |=> !expired);
endmodule

// File: rtl/wrg_burst_len.sv
// Burst duration in clocks, selected per parameter variant.
module wrg_burst_len #(
   parameter int BL_MODE = 2,
   parameter int W       = 5
) (
   input  logic         chop,
   output logic [W-1:0] span
);
   localparam logic [W-1:0] FULL = W'(4);
   localparam logic [W-1:0] HALF = W'(2);

   generate
      if (BL_MODE == 0) begin : g_fixed_full
         assign span = FULL;
      end else if (BL_MODE == 1) begin : g_fixed_chop
         assign span = HALF;
      end else begin : g_on_the_fly
         assign span = chop ? HALF : FULL;
      end
   endgenerate
endmodule

// File: rtl/wrg_bank_track.sv
// Per-bank write recovery and auto-precharge tracking.
module wrg_bank_track #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic         ap,
   input  logic [W-1:0] rec_val,
   input  logic [W-1:0] busy_val,
   output logic         pre_ok,
   output logic         busy
);
   logic rec_done, busy_done;

   wrg_timer #(.W(W)) u_rec (
      .clk(clk), .rst_n(rst_n), .load(wr_hit),
      .val(rec_val), .expired(rec_done)
   );

   wrg_timer #(.W(W)) u_busy (
      .clk(clk), .rst_n(rst_n), .load(wr_hit && ap),
      .val(busy_val), .expired(busy_done)
   );

   assign busy   = !busy_done;
   assign pre_ok = rec_done && busy_done;

   a_r6_ap_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && ap) |=> busy);
   a_r5_wr_blocks_pre: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> !pre_ok);
endmodule

// File: rtl/wr_turnaround_guard.sv
module wr_turnaround_guard #(
   parameter int NUM_BANKS = 8,
   parameter int WL        = 5,
   parameter int T_CCD     = 4,
   parameter int T_WTR     = 4,
   parameter int T_WR      = 8,
   parameter int T_RP      = 5,
   parameter int BL_MODE   = 2,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_vld,
   input  logic [1:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic                 cmd_bc,
   output logic                 wr_ok,
   output logic                 rd_ok,
   output logic [NUM_BANKS-1:0] pre_ok,
   output logic [NUM_BANKS-1:0] bank_busy,
   output logic                 viol,
   output logic [1:0]           viol_op
);
   import wrg_pkg::*;

   localparam int MAX_D = WL + 4 + T_WR + T_RP + T_CCD + T_WTR;
   localparam int CNT_W = $clog2(MAX_D + 1);

   generate
      if (NUM_BANKS < 1)             begin : g_chk_banks $error("NUM_BANKS must be at least 1"); end
      if (T_CCD < 1 || T_WTR < 1)    begin : g_chk_t1    $error("T_CCD and T_WTR must be at least 1"); end
      if (T_WR < 1 || T_RP < 0)      begin : g_chk_t2    $error("T_WR must be at least 1"); end
      if (WL < 1)                    begin : g_chk_wl    $error("WL must be at least 1"); end
      if (BL_MODE < 0 || BL_MODE > 2) begin : g_chk_bl   $error("BL_MODE must be 0, 1 or 2"); end
   endgenerate

   logic             is_wr, is_rd, is_pre;
   logic [CNT_W-1:0] span, end_off;
   logic [CNT_W-1:0] ccd_val, wtr_val, rec_val, busy_val;
   logic             deny;

   assign is_wr  = cmd_vld && (cmd_op == OP_WR);
   assign is_rd  = cmd_vld && (cmd_op == OP_RD);
   assign is_pre = cmd_vld && (cmd_op == OP_PRE);

   wrg_burst_len #(.BL_MODE(BL_MODE), .W(CNT_W)) u_blen (
      .chop(cmd_bc), .span(span)
   );

   // Counters hold D-1 after the command edge, so a delay of D clocks ends in cycle t+D.
   assign end_off  = CNT_W'(WL) + span;
   assign ccd_val  = CNT_W'(T_CCD - 1);
   assign wtr_val  = end_off + CNT_W'(T_WTR - 1);
   assign rec_val  = end_off + CNT_W'(T_WR - 1);
   assign busy_val = end_off + CNT_W'(T_WR + T_RP - 1);

   wrg_timer #(.W(CNT_W)) u_ccd (
      .clk(clk), .rst_n(rst_n), .load(is_wr), .val(ccd_val), .expired(wr_ok)
   );

   wrg_timer #(.W(CNT_W)) u_wtr (
      .clk(clk), .rst_n(rst_n), .load(is_wr), .val(wtr_val), .expired(rd_ok)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         wrg_bank_track #(.W(CNT_W)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(is_wr && (cmd_bank == BANK_W'(b))),
            .ap(cmd_ap),
            .rec_val(rec_val), .busy_val(busy_val),
            .pre_ok(pre_ok[b]), .busy(bank_busy[b])
         );
      end
   endgenerate

   always_comb begin
      deny = 1'b0;
      if (is_rd)  deny = !rd_ok || bank_busy[cmd_bank];
      if (is_wr)  deny = !wr_ok || bank_busy[cmd_bank];
      if (is_pre) deny = !pre_ok[cmd_bank];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol    <= 1'b0;
         viol_op <= OP_NOP;
      end else begin
         viol <= deny;
         if (deny) viol_op <= cmd_op;
      end
   end

   a_r7_op_matches: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> (viol_op == $past(cmd_op)));
   a_r8_op_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !viol |-> $stable(viol_op));
   a_r7_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> !viol);
   a_r4_wr_blocks_rd: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |=> !rd_ok);
   a_r2_wr_blocks_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && T_CCD > 1) |=> !wr_ok);
endmodule

// File: tb/wr_turnaround_guard_bench.sv
module wr_turnaround_guard_bench;
   localparam int NB = 4, WL = 5, TCCD = 4, TWTR = 4, TWR = 8, TRP = 5;

   typedef struct { bit v; int op; } exp_t;

   logic clk = 0, rst_n = 0;
   logic cmd_vld = 0, cmd_ap = 0, cmd_bc = 0;
   logic [1:0] cmd_op = 0, cmd_bank = 0;
   logic wr_ok, rd_ok, viol;
   logic [NB-1:0] pre_ok, bank_busy;
   logic [1:0] viol_op;

   int total = 0, bad = 0, now = 0;
   int wr_at = 0, rd_at = 0;
   int pre_at [NB];
   int busy_at [NB];
   int last_op = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   wr_turnaround_guard #(.NUM_BANKS(NB), .WL(WL), .T_CCD(TCCD), .T_WTR(TWTR),
      .T_WR(TWR), .T_RP(TRP), .BL_MODE(2)) u_wr_turnaround_guard (
      .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
      .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_bc(cmd_bc),
      .wr_ok(wr_ok), .rd_ok(rd_ok), .pre_ok(pre_ok), .bank_busy(bank_busy),
      .viol(viol), .viol_op(viol_op));

   always @(posedge clk) if (rst_n) now <= now + 1;

   task automatic chk(bit good, string tag, int act, int exp);
      total++;
      if (!good) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, now, act, exp);
      end
   endtask

   function automatic int mx(int a, int b); return a > b ? a : b; endfunction

   // Driver: checks flags against the model, drives one command, pushes the expected result.
   task automatic step(bit v, int op, int bk, bit ap, bit bc);
      exp_t e;
      bit ew, er, ep, eb, deny;
      @(negedge clk);
      ew = now >= wr_at;
      er = now >= rd_at;
      chk(wr_ok == ew, "R2 wr_ok", wr_ok, ew);
      chk(rd_ok == er, "R4 rd_ok", rd_ok, er);
      for (int b = 0; b < NB; b++) begin
         ep = (now >= pre_at[b]) && (now >= busy_at[b]);
         eb = now < busy_at[b];
         chk(pre_ok[b] == ep, "R5 pre_ok", pre_ok[b], ep);
         chk(bank_busy[b] == eb, "R6 bank_busy", bank_busy[b], eb);
      end
      deny = 0;
      if (v) begin
         if (op == 1) deny = !er || (now < busy_at[bk]);
         if (op == 2) deny = !ew || (now < busy_at[bk]);
         if (op == 3) deny = !((now >= pre_at[bk]) && (now >= busy_at[bk]));
      end
      e.v = deny; e.op = op;
      q.push_back(e);
      cmd_vld = v; cmd_op = 2'(op); cmd_bank = 2'(bk); cmd_ap = ap; cmd_bc = bc;
      if (v && op == 2) begin  // R9: even a denied write starts its timers
         int fin;
         fin = now + WL + (bc ? 2 : 4);  // R3 burst end
         wr_at = mx(wr_at, now + TCCD);
         rd_at = mx(rd_at, fin + TWTR);
         pre_at[bk] = mx(pre_at[bk], fin + TWR);
         if (ap) busy_at[bk] = mx(busy_at[bk], fin + TWR + TRP);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
   endtask

   // Monitor: compares the registered violation outputs one cycle after each command.
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(viol == e.v, "R7 viol", viol, e.v);
         if (e.v) last_op = e.op;
         chk(viol_op == 2'(last_op), "R8 viol_op", viol_op, last_op);
      end
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      chk(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      for (int b = 0; b < NB; b++) begin pre_at[b] = 0; busy_at[b] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      @(negedge clk);
      chk(wr_ok && rd_ok, "R1 ok flags", {wr_ok, rd_ok}, 3);
      chk(pre_ok == '1 && bank_busy == '0, "R1 bank flags", {pre_ok, bank_busy}, 8'hF0);
      chk(viol == 0, "R1 viol", viol, 0);
      // R2, R3: full burst then chopped burst exactly T_CCD later, then one too early
      step(1, 2, 0, 0, 0);
      idle(TCCD - 1);
      step(1, 2, 1, 0, 1);
      idle(TCCD - 2);
      step(1, 2, 1, 0, 0);   // R2 early write, R9 still counted
      idle(20);
      // R4 early read, R5 early precharge, R8 hold across idles
      step(1, 2, 3, 0, 0);
      idle(2);
      step(1, 1, 0, 0, 0);
      idle(3);
      step(1, 3, 3, 0, 0);
      step(1, 3, 0, 0, 0);   // R5 other bank unaffected
      idle(25);
      // R6 auto precharge: read after rd_ok returns but bank still busy
      step(1, 2, 2, 1, 0);
      idle(13);
      step(1, 1, 2, 0, 0);
      step(1, 1, 1, 0, 0);
      idle(1);
      step(1, 3, 2, 0, 0);
      step(1, 2, 2, 0, 0);
      idle(30);
      // R10 invalid cycle carrying a write has no effect
      step(0, 2, 0, 1, 0);
      step(1, 2, 0, 0, 0);
      idle(3);
      // R3 chopped burst: precharge on the exact recovery edge
      step(1, 2, 1, 0, 1);
      idle(WL + 2 + TWR - 1);
      step(1, 3, 1, 0, 0);
      idle(25);
      step(1, 1, 3, 0, 0);
      idle(3);
      finish_run();
   end
endmodule